// File: doc/BRIEF.md
# Timeout-Fallback Interrupt Delivery Arbiter

This block decides which processor cores see an interrupt request line while the interrupt controller holds a pending event. Interrupt sources cannot be steered to particular cores; the arbiter alone picks the recipient. It first raises the line of a single core. It prefers a core that is awake and sits in the preferred cluster, so that sleeping cores are not woken. If nobody acknowledges within a programmable number of cycles, it raises the line of every core that has opted in. One acknowledge strobe is shared by all cores, and the first core to acknowledge takes the event.

Each core holds a two-bit opt-in setting, written through a small write port. A zero setting excludes the core from delivery. Cores are split into two clusters at a parameterized index. The lower cores form the efficiency cluster, which is tried first by default. A preference input switches the first choice to the upper, performance cluster.

Top module: `irq_fallback_arbiter`

## Requirements
- R1: During the first, single-target delivery phase exactly one bit of `irq_o` is high.
- R2: A core whose two-bit opt-in value is 0 never has its line raised. Both nonzero values count as opted in. After reset only core 0 holds a nonzero opt-in value (1); all others hold 0.
- R3: The single target is the lowest-indexed core in the preferred cluster that is opted in and not idle (`core_idle_i` bit low).
- R4: If the preferred cluster has no such core, the lowest-indexed opted-in non-idle core of the other cluster is chosen. If none exists there either, the lowest-indexed opted-in core is chosen.
- R5: With `prefer_perf_i` low the preferred cluster is cores 0 to SPLIT-1. With it high the preferred cluster is cores SPLIT to NUM_CORES-1.
- R6: With a timeout value T greater than 0 sampled when delivery starts, the single target's line is high for T cycles. It is then replaced by all opted-in cores' lines.
- R7: A timeout value of 0 makes delivery start directly with the broadcast to all opted-in cores.
- R8: An acknowledge during delivery drives all lines low in the next cycle. If the event is still pending, a new selection round raises a line one cycle after that.
- R9: While `enable_i` is low, or while no core is opted in, all lines are low from the next cycle on.
- R10: During broadcast the set of raised lines follows the opt-in settings, so a core opted out mid-broadcast drops one cycle after its write takes effect.
- R11: `irq_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Global delivery enable |
| event_pending_i | input | 1 | Controller has an event waiting |
| ack_i | input | 1 | Shared acknowledge strobe, one cycle |
| prefer_perf_i | input | 1 | 1 selects the performance cluster as first choice |
| timeout_i | input | TMO_W | Cycles of single delivery before broadcast |
| core_idle_i | input | NUM_CORES | Per-core wait-for-interrupt status |
| optin_wr_i | input | 1 | Write strobe for one opt-in setting |
| optin_wr_core_i | input | IDX_W | Core whose opt-in setting is written |
| optin_wr_val_i | input | 2 | New opt-in value |
| irq_o | output | NUM_CORES | Registered interrupt line per core |

## Verification
The bench builds idle patterns that empty the preferred cluster, then both clusters, of awake cores. A picker with the fallback order reversed or the cluster split misplaced raises the wrong line. It counts the single-target cycles against a timeout of five. An off-by-one counter would broadcast a cycle early or late, and a mishandled zero timeout would stall on a single core. It also opts a core out mid-broadcast and disables the block mid-delivery, where a design that latched the broadcast mask, or ignored the enable, would keep the lines high.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_SINGLE = 2'd1,
    ARB_BCAST  = 2'd2
  } arb_state_e;

  localparam int OPTIN_W = 2;
endpackage

// File: rtl/irq_optin_bank.sv
module irq_optin_bank #(
  parameter int NUM_CORES = 8,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_core,
  input  logic [irq_arb_pkg::OPTIN_W-1:0] wr_val,
  output logic [NUM_CORES-1:0]            opted_o
);
  import irq_arb_pkg::*;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam logic [OPTIN_W-1:0] RST_VAL = (g == 0) ? OPTIN_W'(1) : '0;
    logic [OPTIN_W-1:0] setting_q;

    always_ff @(posedge clk) begin
      if (rst)
        setting_q <= RST_VAL;
      else if (wr_en && (wr_core == IDX_W'(g)))
        setting_q <= wr_val;
    end

    assign opted_o[g] = |setting_q;
  end

  // R2: reset leaves only core 0 opted in
  assert_reset_optin_R2: assert property (@(posedge clk)
    $past(rst) |-> (opted_o == NUM_CORES'(1)));
endmodule

// File: rtl/irq_core_picker.sv
module irq_core_picker #(
  parameter int NUM_CORES = 8,
  parameter int SPLIT     = 4,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic [NUM_CORES-1:0] opted_i,
  input  logic [NUM_CORES-1:0] idle_i,
  input  logic                 prefer_perf_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [NUM_CORES-1:0] pref_mask;
  logic [NUM_CORES-1:0] awake;
  logic [NUM_CORES-1:0] tier_a;
  logic [NUM_CORES-1:0] tier_b;
  logic [NUM_CORES-1:0] pool;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_mask
    assign pref_mask[g] = prefer_perf_i ? (g >= SPLIT) : (g < SPLIT);
  end

  assign awake  = opted_i & ~idle_i;
  assign tier_a = awake & pref_mask;
  assign tier_b = awake & ~pref_mask;

  always_comb begin
    if (|tier_a)      pool = tier_a;
    else if (|tier_b) pool = tier_b;
    else              pool = opted_i;
  end

  always_comb begin
    idx_o = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (pool[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |opted_i;

  // R2: a chosen core is always opted in
  always_comb begin
    if (valid_o) assert_pick_opted_R2: assert (opted_i[idx_o] || $isunknown(opted_i));
  end
endmodule

// File: rtl/irq_timeout_timer.sv
module irq_timeout_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (dec_i && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == TMO_W'(1));

  // R6: the countdown steps by exactly one per delivery cycle
  assert_countdown_step_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_fallback_arbiter.sv
module irq_fallback_arbiter #(
  parameter int NUM_CORES = 8,
  parameter int SPLIT     = 4,
  parameter int TMO_W     = 16,
  parameter int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable_i,
  input  logic                 event_pending_i,
  input  logic                 ack_i,
  input  logic                 prefer_perf_i,
  input  logic [TMO_W-1:0]     timeout_i,
  input  logic [NUM_CORES-1:0] core_idle_i,
  input  logic                 optin_wr_i,
  input  logic [IDX_W-1:0]     optin_wr_core_i,
  input  logic [1:0]           optin_wr_val_i,
  output logic [NUM_CORES-1:0] irq_o
);
  import irq_arb_pkg::*;

  arb_state_e           state_q;
  logic [NUM_CORES-1:0] irq_q;
  logic [NUM_CORES-1:0] opted;
  logic                 pick_valid;
  logic [IDX_W-1:0]     pick_idx;
  logic                 tmr_last;
  logic                 start_round;
  logic                 start_single;
  logic                 tmo_zero;

  irq_optin_bank #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_optin (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (optin_wr_i),
    .wr_core (optin_wr_core_i),
    .wr_val  (optin_wr_val_i),
    .opted_o (opted)
  );

  irq_core_picker #(.NUM_CORES(NUM_CORES), .SPLIT(SPLIT), .IDX_W(IDX_W)) u_pick (
    .opted_i       (opted),
    .idle_i        (core_idle_i),
    .prefer_perf_i (prefer_perf_i),
    .valid_o       (pick_valid),
    .idx_o         (pick_idx)
  );

  assign tmo_zero     = (timeout_i == '0);
  assign start_round  = (state_q == ARB_IDLE) && enable_i && pick_valid && event_pending_i;
  assign start_single = start_round && !tmo_zero;

  irq_timeout_timer #(.TMO_W(TMO_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_single),
    .load_val_i (timeout_i),
    .dec_i      (state_q == ARB_SINGLE),
    .last_o     (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      irq_q   <= '0;
    end else if (!enable_i || !pick_valid) begin
      state_q <= ARB_IDLE;
      irq_q   <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (start_round) begin
            if (tmo_zero) begin
              state_q <= ARB_BCAST;
              irq_q   <= opted;
            end else begin
              state_q <= ARB_SINGLE;
              irq_q   <= NUM_CORES'(1) << pick_idx;
            end
          end
        end
        ARB_SINGLE: begin
          if (ack_i || ((irq_q & opted) == '0)) begin
            state_q <= ARB_IDLE;
            irq_q   <= '0;
          end else if (tmr_last) begin
            state_q <= ARB_BCAST;
            irq_q   <= opted;
          end
        end
        ARB_BCAST: begin
          if (ack_i) begin
            state_q <= ARB_IDLE;
            irq_q   <= '0;
          end else begin
            irq_q <= opted;
          end
        end
        default: begin
          state_q <= ARB_IDLE;
          irq_q   <= '0;
        end
      endcase
    end
  end

  assign irq_o = irq_q;

  // R1: single-target phase drives exactly one line
  assert_single_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ARB_SINGLE) |-> $onehot(irq_o));

  // R2: no line for a core that was opted out when the outputs were computed
  assert_optout_silent_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((irq_o & ~$past(opted)) == '0));

  // R8: acknowledge during delivery clears every line next cycle
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && (state_q != ARB_IDLE)) |=> (irq_o == '0));

  // R9: disabled block keeps all lines low
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (irq_o == '0));

  // R11: outputs low right after reset
  assert_reset_low_R11: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0));
endmodule

// File: tb/irq_fallback_arbiter_bench.sv
module irq_fallback_arbiter_bench;
  localparam int N     = 8;
  localparam int TW    = 16;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          enable_i;
  logic          event_pending_i;
  logic          ack_i;
  logic          prefer_perf_i;
  logic [TW-1:0] timeout_i;
  logic [N-1:0]  core_idle_i;
  logic          optin_wr_i;
  logic [IW-1:0] optin_wr_core_i;
  logic [1:0]    optin_wr_val_i;
  logic [N-1:0]  irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_fallback_arbiter #(.NUM_CORES(N), .SPLIT(4), .TMO_W(TW)) u_irq_fallback_arbiter (
    .clk             (clk),
    .rst             (rst),
    .enable_i        (enable_i),
    .event_pending_i (event_pending_i),
    .ack_i           (ack_i),
    .prefer_perf_i   (prefer_perf_i),
    .timeout_i       (timeout_i),
    .core_idle_i     (core_idle_i),
    .optin_wr_i      (optin_wr_i),
    .optin_wr_core_i (optin_wr_core_i),
    .optin_wr_val_i  (optin_wr_val_i),
    .irq_o           (irq_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp);
    n_checks++;
    if (irq_o !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%b expected=%b", req, irq_o, exp);
    end
  endtask

  task automatic write_optin(input int core, input logic [1:0] val);
    optin_wr_i      = 1'b1;
    optin_wr_core_i = IW'(core);
    optin_wr_val_i  = val;
    step(1);
    optin_wr_i = 1'b0;
  endtask

  task automatic finish_round();
    event_pending_i = 1'b0;
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
    step(1);
  endtask

  task automatic t_reset_default();
    rst = 1'b1; enable_i = 1'b0; event_pending_i = 1'b0; ack_i = 1'b0;
    prefer_perf_i = 1'b0; timeout_i = 16'd100; core_idle_i = '0;
    optin_wr_i = 1'b0; optin_wr_core_i = '0; optin_wr_val_i = '0;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R11 reset", 8'h00);
    enable_i = 1'b1;
    core_idle_i = 8'h01;
    event_pending_i = 1'b1;
    step(1);
    chk("R2 only core0 opted after reset", 8'h01);
    finish_round();
  endtask

  task automatic t_select();
    for (int c = 1; c < N; c++) write_optin(c, (c % 2 == 0) ? 2'b10 : 2'b01);
    core_idle_i = 8'b0000_0011; prefer_perf_i = 1'b0; event_pending_i = 1'b1;
    step(1);
    chk("R3 lowest awake in efficiency cluster", 8'h04);
    finish_round();
    core_idle_i = 8'h00; prefer_perf_i = 1'b1; event_pending_i = 1'b1;
    step(1);
    chk("R5 performance cluster preferred", 8'h10);
    finish_round();
    core_idle_i = 8'h30; event_pending_i = 1'b1;
    step(1);
    chk("R3 skip idle cores in preferred cluster", 8'h40);
    finish_round();
  endtask

  task automatic t_fallback();
    prefer_perf_i = 1'b0; core_idle_i = 8'h0F; event_pending_i = 1'b1;
    step(1);
    chk("R4 other cluster when preferred all idle", 8'h10);
    finish_round();
    core_idle_i = 8'hFF; event_pending_i = 1'b1;
    step(1);
    chk("R4 any opted core when all idle", 8'h01);
    finish_round();
  endtask

  task automatic t_timeout_bcast();
    core_idle_i = 8'h00; prefer_perf_i = 1'b0; timeout_i = 16'd5;
    event_pending_i = 1'b1;
    step(1);
    n_checks++;
    if ($countones(irq_o) != 1) begin
      n_fail++;
      $display("FAIL R1: irq_o=%b expected one bit set", irq_o);
    end
    chk("R6 single target first cycle", 8'h01);
    step(4);
    chk("R6 single target last cycle", 8'h01);
    step(1);
    chk("R6 broadcast after timeout", 8'hFF);
    write_optin(3, 2'b00);
    step(1);
    chk("R10 opted-out core drops from broadcast", 8'hF7);
    ack_i = 1'b1;
    step(1);
    chk("R8 ack clears all lines", 8'h00);
    ack_i = 1'b0;
    step(1);
    chk("R8 new round while still pending", 8'h01);
    finish_round();
  endtask

  task automatic t_zero_timeout();
    timeout_i = 16'd0; event_pending_i = 1'b1;
    step(1);
    chk("R7 zero timeout broadcasts at once", 8'hF7);
    finish_round();
  endtask

  task automatic t_quiet();
    timeout_i = 16'd50; event_pending_i = 1'b1;
    step(1);
    chk("R6 delivery before disable", 8'h01);
    enable_i = 1'b0;
    step(1);
    chk("R9 disable clears lines", 8'h00);
    step(2);
    chk("R9 stays low while disabled", 8'h00);
    enable_i = 1'b1;
    for (int c = 0; c < N; c++) write_optin(c, 2'b00);
    step(2);
    chk("R9 no opted core keeps lines low", 8'h00);
    finish_round();
  endtask

  initial begin
    t_reset_default();
    t_select();
    t_fallback();
    t_timeout_bcast();
    t_zero_timeout();
    t_quiet();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule